// File: doc/BRIEF.md
# Pulse or Level Interrupt Request Output

This block produces the active-low interrupt request line of a bus controller. It watches per-cycle event strobes for a set of interrupt status registers (two by default), keeps only those events that the matching mask register enables, and turns any surviving event into a request on `irq_n`.

A style bit in a configuration word picks one of two output behaviours.

- **Pulse style:** the line drops for a fixed time of about 500 ns. That time stays constant because the count is chosen from a 2-bit clock-rate select covering 10, 12, 16 and 20 MHz.
- **Level style:** the line stays low until it is cleared.

A level request is cleared in one of two ways:

- The host writes a 1 to the interrupt-reset bit of the start/reset register.
- When an auto-clear bit is set, the host reads the status registers. Each status register has its own pending flag, and a read releases only that register's flag. The line goes high only once every flag has been released.

Top module: `irq_request_out`

## Requirements
- R1: While reset is asserted and after it is released with no event, `irq_n` is 1, and no pending state survives reset.
- R2: With configuration bit 3 at 0 (pulse style), an enabled event sampled on a clock edge drives `irq_n` low from that edge for exactly N cycles. N is 5, 6, 8 or 10 for `clk_sel` values 0, 1, 2 and 3, which stand for 10, 12, 16 and 20 MHz.
- R3: An event bit whose mask bit is 0 causes no request in either style. A mask bit of 1 enables the event bit at the same position in the same status register. Register i occupies bits [16i+15:16i] of `evt_bits` and `evt_mask`.
- R4: With configuration bit 3 at 1 (level style), an enabled event drives `irq_n` low from the next edge, and it stays low until a clear.
- R5: A host write (`host_stb`=1, `host_wr`=1) to address 3 with `host_wdata` bit 2 at 1 clears every pending flag. A write with bit 2 at 0, or a write to any other address, leaves the request unchanged.
- R6: With configuration bit 3 at 1 and bit 4 at 1 (auto-clear), a host read of address 4+i clears the pending flag of status register i. `irq_n` returns high only when all flags are clear. With bit 4 at 0, reads have no effect.
- R7: An enabled event in the same cycle as a clear of its register leaves that register pending.
- R8: In pulse style, an enabled event during an active pulse restarts the full N-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| evt_bits | input | NUM_STAT*EVT_W | Per-cycle event strobes, one slice per status register |
| evt_mask | input | NUM_STAT*EVT_W | Mask register contents, 1 enables the event bit |
| cfg_word | input | CFG_W | Configuration word: bit 3 selects level style, bit 4 enables auto-clear |
| host_stb | input | 1 | Host register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| clk_sel | input | 2 | Clock-rate select: 0=10, 1=12, 2=16, 3=20 MHz |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach is auto-clear level style with both status registers pending, where the host reads the registers one at a time. The line must stay low after the first read and rise only after the second. A new event landing on the same edge as a clear is equally awkward to reach.

The bench drives both of these cases as directed sequences. It then runs a long seeded random phase that biases host accesses towards the three decoded addresses and changes the style, auto-clear and clock-rate settings every hundred cycles, so that requests are cut across mode changes and retriggered mid-pulse.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

   typedef enum logic [1:0] {
      RATE_10MHZ = 2'd0,
      RATE_12MHZ = 2'd1,
      RATE_16MHZ = 2'd2,
      RATE_20MHZ = 2'd3
   } clk_rate_e;

   function automatic int unsigned rate_mhz(input clk_rate_e r);
      case (r)
         RATE_10MHZ: return 10;
         RATE_12MHZ: return 12;
         RATE_16MHZ: return 16;
         default:    return 20;
      endcase
   endfunction

   // Cycles needed to span width_ns at the selected clock, never below one.
   function automatic int unsigned pulse_cycles(input clk_rate_e r, input int unsigned width_ns);
      int unsigned c;
      c = (width_ns * rate_mhz(r)) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/irq_host_decode.sv
module irq_host_decode #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_STAT   = 2,
   parameter int unsigned START_ADDR = 3,
   parameter int unsigned STAT_BASE  = 4,
   parameter int unsigned CLR_BIT    = 2
) (
   input  logic                host_stb,
   input  logic                host_wr,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic                auto_clr,
   output logic                wr_clear,
   output logic [NUM_STAT-1:0] rd_clear
);

   logic unused_wdata;
   assign unused_wdata = ^host_wdata;

   // Interrupt-reset bit written to the start/reset register.
   assign wr_clear = host_stb && host_wr
                     && (host_addr == ADDR_W'(START_ADDR))
                     && host_wdata[CLR_BIT];

   // Reads of each status register, effective only under auto-clear.
   for (genvar i = 0; i < NUM_STAT; i++) begin : g_rd
      assign rd_clear[i] = host_stb && !host_wr && auto_clr
                           && (host_addr == ADDR_W'(STAT_BASE + i));
   end

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
   parameter int unsigned NUM_STAT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [NUM_STAT-1:0] hit,
   input  logic                wr_clear,
   input  logic [NUM_STAT-1:0] rd_clear,
   output logic [NUM_STAT-1:0] pend
);

   for (genvar i = 0; i < NUM_STAT; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
         end else if (!enable) begin
            pend[i] <= 1'b0;
         end else if (hit[i]) begin
            pend[i] <= 1'b1;
         end else if (wr_clear || rd_clear[i]) begin
            pend[i] <= 1'b0;
         end
      end

      AST_PEND_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> $past(hit[i]));                                   // R3
      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (enable && pend[i] && !wr_clear && !rd_clear[i]) |=> pend[i]);       // R4
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (enable && hit[i]) |=> pend[i]);                                     // R7
      AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend[i]) |-> $past(wr_clear || rd_clear[i] || !enable));       // R6
   end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
   import irq_out_pkg::*;
#(
   parameter int unsigned PULSE_NS  = 500,
   parameter int unsigned CNT_W     = 4,
   parameter bit          RETRIGGER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       trigger,
   input  logic [1:0] clk_sel,
   output logic       active
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len;
   logic             load;

   always_comb len = CNT_W'(pulse_cycles(clk_rate_e'(clk_sel), PULSE_NS));

   if (RETRIGGER) begin : g_retrig
      assign load = trigger;
   end else begin : g_oneshot
      assign load = trigger && (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!enable) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= len;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign active = (cnt != '0);

   AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && load) |=> (cnt == $past(len)));                               // R2
   AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && active && !load) |=> (cnt == $past(cnt) - 1'b1));             // R2

endmodule

// File: rtl/irq_request_out.sv
module irq_request_out
   import irq_out_pkg::*;
#(
   parameter int unsigned NUM_STAT    = 2,
   parameter int unsigned EVT_W       = 16,
   parameter int unsigned CFG_W       = 16,
   parameter int unsigned LEVEL_BIT   = 3,
   parameter int unsigned AUTOCLR_BIT = 4,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned START_ADDR  = 3,
   parameter int unsigned STAT_BASE   = 4,
   parameter int unsigned CLR_BIT     = 2,
   parameter int unsigned PULSE_NS    = 500,
   parameter bit          RETRIGGER   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_STAT*EVT_W-1:0] evt_bits,
   input  logic [NUM_STAT*EVT_W-1:0] evt_mask,
   input  logic [CFG_W-1:0]          cfg_word,
   input  logic                      host_stb,
   input  logic                      host_wr,
   input  logic [ADDR_W-1:0]         host_addr,
   input  logic [DATA_W-1:0]         host_wdata,
   input  logic [1:0]                clk_sel,
   output logic                      irq_n
);

   localparam int unsigned MAX_LEN = pulse_cycles(RATE_20MHZ, PULSE_NS);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   if (LEVEL_BIT >= CFG_W || AUTOCLR_BIT >= CFG_W || LEVEL_BIT == AUTOCLR_BIT) begin : g_bad_cfg
      $error("irq_request_out: configuration bit positions invalid");
   end
   if (CLR_BIT >= DATA_W) begin : g_bad_clr
      $error("irq_request_out: clear bit outside write data");
   end
   if (NUM_STAT < 1 || EVT_W < 1) begin : g_bad_stat
      $error("irq_request_out: need at least one status register and event bit");
   end
   if (STAT_BASE + NUM_STAT > (1 << ADDR_W) || START_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_request_out: register addresses exceed address width");
   end
   if (START_ADDR >= STAT_BASE && START_ADDR < STAT_BASE + NUM_STAT) begin : g_bad_overlap
      $error("irq_request_out: start/reset address overlaps status registers");
   end

   logic                unused_cfg;
   logic                level_mode;
   logic                auto_clr;
   logic [NUM_STAT-1:0] hit;
   logic                wr_clear;
   logic [NUM_STAT-1:0] rd_clear;
   logic [NUM_STAT-1:0] pend;
   logic                pulse_on;

   assign unused_cfg = ^cfg_word;
   assign level_mode = cfg_word[LEVEL_BIT];
   assign auto_clr   = cfg_word[AUTOCLR_BIT];

   for (genvar i = 0; i < NUM_STAT; i++) begin : g_hit
      assign hit[i] = |(evt_bits[i*EVT_W +: EVT_W] & evt_mask[i*EVT_W +: EVT_W]);
   end

   irq_host_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_STAT  (NUM_STAT),
      .START_ADDR(START_ADDR),
      .STAT_BASE (STAT_BASE),
      .CLR_BIT   (CLR_BIT)
   ) i_decode (
      .host_stb  (host_stb),
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .auto_clr  (auto_clr),
      .wr_clear  (wr_clear),
      .rd_clear  (rd_clear)
   );

   irq_pend_track #(
      .NUM_STAT(NUM_STAT)
   ) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (level_mode),
      .hit     (hit),
      .wr_clear(wr_clear),
      .rd_clear(rd_clear),
      .pend    (pend)
   );

   irq_pulse_timer #(
      .PULSE_NS (PULSE_NS),
      .CNT_W    (CNT_W),
      .RETRIGGER(RETRIGGER)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (!level_mode),
      .trigger(|hit),
      .clk_sel(clk_sel),
      .active (pulse_on)
   );

   assign irq_n = level_mode ? !(|pend) : !pulse_on;

   AST_NO_MASKED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && !pulse_on && !(|hit)) |=> (pulse_on == 1'b0 || $past(level_mode) != level_mode)); // R3
   AST_RESET_CLEARS: assert property (@(posedge clk)
      $rose(rst_n) |-> (pend == '0 && !pulse_on));                            // R1

endmodule

// File: tb/test_irq_request_out.sv
module test_irq_request_out;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_bits = '0;
   logic [31:0] evt_mask = '0;
   logic [15:0] cfg_word = '0;
   logic        host_stb = 1'b0;
   logic        host_wr = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  clk_sel = '0;
   logic        irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   irq_request_out i_irq_request_out (
      .clk(clk), .rst_n(rst_n), .evt_bits(evt_bits), .evt_mask(evt_mask),
      .cfg_word(cfg_word), .host_stb(host_stb), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .clk_sel(clk_sel),
      .irq_n(irq_n)
   );

   function automatic int exp_len(input logic [1:0] s);
      case (s)
         2'd0: return 5;
         2'd1: return 6;
         2'd2: return 8;
         default: return 10;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model from the requirements, compared on every rising edge
   // before it advances.
   int m_cnt = 0;
   bit [1:0] m_pend = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         m_pend = '0;
      end else begin
         bit exp_irq;
         bit [1:0] hitv;
         bit wclr;
         bit [1:0] rclr;
         exp_irq = cfg_word[3] ? !(|m_pend) : (m_cnt == 0);
         check(irq_n === exp_irq, cfg_word[3] ? "R4 model" : "R2 model", int'(irq_n), int'(exp_irq));
         hitv[0] = |(evt_bits[15:0] & evt_mask[15:0]);
         hitv[1] = |(evt_bits[31:16] & evt_mask[31:16]);
         wclr = host_stb && host_wr && host_addr == 5'd3 && host_wdata[2];
         rclr[0] = host_stb && !host_wr && host_addr == 5'd4 && cfg_word[4];
         rclr[1] = host_stb && !host_wr && host_addr == 5'd5 && cfg_word[4];
         if (!cfg_word[3]) begin
            m_pend = '0;
            if (|hitv) m_cnt = exp_len(clk_sel);
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
         end else begin
            m_cnt = 0;
            for (int i = 0; i < 2; i++) begin
               if (hitv[i]) m_pend[i] = 1'b1;
               else if (wclr || rclr[i]) m_pend[i] = 1'b0;
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic fire(input int pos);
      evt_bits = 32'd1 << pos;
      tick();
      evt_bits = '0;
   endtask

   task automatic host(input bit wr, input logic [4:0] a, input logic [15:0] d);
      host_stb = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      tick();
      host_stb = 1'b0; host_wr = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog R2: run did not end, actual 1 expected 0");
         summary();
      end
   end

   initial begin
      int lows;
      void'($urandom(32'd20240611));
      repeat (3) tick();
      check(irq_n === 1'b1, "R1 in reset", int'(irq_n), 1);
      cfg_word = 16'h0008;
      evt_mask = '1;
      rst_n = 1'b1;
      repeat (2) tick();
      check(irq_n === 1'b1, "R1 after reset", int'(irq_n), 1);

      // R2: pulse width for each rate
      cfg_word = 16'h0000;
      for (int s = 0; s < 4; s++) begin
         clk_sel = 2'(s);
         fire(s);
         lows = 0;
         while (irq_n === 1'b0 && lows < 30) begin
            lows++;
            tick();
         end
         check(lows == exp_len(2'(s)), "R2 pulse length", lows, exp_len(2'(s)));
         repeat (2) tick();
      end

      // R3: masked events in both styles
      evt_mask = 32'hFFFF_FFFF & ~(32'd1 << 5) & ~(32'd1 << 20);
      fire(5);
      check(irq_n === 1'b1, "R3 masked pulse", int'(irq_n), 1);
      cfg_word = 16'h0008;
      fire(20);
      repeat (3) tick();
      check(irq_n === 1'b1, "R3 masked level", int'(irq_n), 1);
      fire(21);
      check(irq_n === 1'b0, "R3 enabled level", int'(irq_n), 0);

      // R4: level holds
      repeat (20) tick();
      check(irq_n === 1'b0, "R4 level held", int'(irq_n), 0);

      // R5: write clearing
      host(1'b1, 5'd3, 16'hFFFB);
      check(irq_n === 1'b0, "R5 bit2 zero ignored", int'(irq_n), 0);
      host(1'b1, 5'd4, 16'h0004);
      check(irq_n === 1'b0, "R5 other address ignored", int'(irq_n), 0);
      host(1'b1, 5'd3, 16'h0004);
      check(irq_n === 1'b1, "R5 write clears", int'(irq_n), 1);

      // R6: auto-clear needs both reads
      cfg_word = 16'h0018;
      evt_bits = 32'h0001_0001;
      tick();
      evt_bits = '0;
      host(1'b0, 5'd4, '0);
      check(irq_n === 1'b0, "R6 one read keeps low", int'(irq_n), 0);
      host(1'b0, 5'd5, '0);
      check(irq_n === 1'b1, "R6 both reads release", int'(irq_n), 1);
      cfg_word = 16'h0008;
      fire(3);
      host(1'b0, 5'd4, '0);
      check(irq_n === 1'b0, "R6 read without auto-clear ignored", int'(irq_n), 0);
      host(1'b1, 5'd3, 16'h0004);
      check(irq_n === 1'b1, "R5 clear after ignored read", int'(irq_n), 1);

      // R7: set wins over same-cycle clear
      fire(2);
      host_stb = 1'b1; host_wr = 1'b1; host_addr = 5'd3; host_wdata = 16'h0004;
      evt_bits = 32'd1 << 2;
      tick();
      host_stb = 1'b0; evt_bits = '0;
      check(irq_n === 1'b0, "R7 set wins", int'(irq_n), 0);
      host(1'b1, 5'd3, 16'h0004);
      check(irq_n === 1'b1, "R7 cleared afterwards", int'(irq_n), 1);

      // R8: retrigger restarts full length
      cfg_word = 16'h0000;
      clk_sel = 2'd0;
      fire(1);
      lows = (irq_n === 1'b0) ? 1 : 0;
      repeat (2) begin
         tick();
         if (irq_n === 1'b0) lows++;
      end
      fire(1);
      while (irq_n === 1'b0 && lows < 40) begin
         lows++;
         tick();
      end
      check(lows == 3 + exp_len(2'd0), "R8 retrigger length", lows, 3 + exp_len(2'd0));

      // Seeded random phase checked by the model
      for (int c = 0; c < 4000; c++) begin
         if (c % 100 == 0) begin
            cfg_word = 16'($urandom);
            clk_sel = 2'($urandom);
            evt_mask = $urandom;
         end
         evt_bits[15:0]  = ($urandom % 6 == 0) ? 16'($urandom) : 16'h0;
         evt_bits[31:16] = ($urandom % 6 == 0) ? 16'($urandom) : 16'h0;
         host_stb = ($urandom % 4 == 0);
         host_wr = 1'($urandom);
         case ($urandom % 4)
            0: host_addr = 5'd3;
            1: host_addr = 5'd4;
            2: host_addr = 5'd5;
            default: host_addr = 5'($urandom);
         endcase
         host_wdata = 16'($urandom);
         tick();
      end
      evt_bits = '0;
      host_stb = 1'b0;
      repeat (2) tick();
      finished = 1'b1;
      summary();
   end

endmodule